// File: doc/BRIEF.md
# Chaotic Permutation-Polynomial Keystream Generator

This block is a stream-cipher core. Its state is `M_WORDS` words of `N_BITS` bits each, loaded directly from a key. On every accepted transfer the state takes one step through a chain of quadratic permutation polynomials modulo 2^N. Each map in the chain takes its parameter from the word updated just before it, which makes the chain a skew product. Every word is then rotated left. The rotated state is the keystream for that transfer.

Data moves on a valid/ready stream. The output word is the input word XOR the keystream, so the same core both encrypts and decrypts. Two cores loaded with the same key, placed one after the other, return the original data. The key length is `M_WORDS*N_BITS`. A 128-bit key (32x4) and a 512-bit key (64x8) are both obtained by changing only the parameters.

Top module: `chaos_keystream_core`

## Requirements
- R1: The map is f(p,x) = 2·x² + g(p)·x mod 2^N, keeping only the low N bits of each product. g(p) is p with its two least significant bits forced to 1, so f(4,x) equals f(7,x).
- R2: For every parameter value p, f(p,·) is a bijection on N-bit words. This holds exhaustively for N=8, and f(p,x) always has the same least significant bit as x.
- R3: One step proceeds as follows. The new word 0 is f(C, old word 0), where C is the nibble 0xB repeated across N bits. For each i from 1 up to M−1, the new word i is f(new word i−1, old word i), using the unrotated new word i−1. A state of all zeros stays all zeros.
- R4: After the chain, every word is rotated left by N/4 bits. The keystream is the full rotated state, with word i at bits [i·N +: N]. With key 1 (word 0 = 1, others 0) at 32x4, the first keystream is 0x...0000_BBBBBDBB.
- R5: While out_valid_o is high, out_data_o equals in_data_i XOR the state after one step from the current registered state. This result appears in the same cycle, with no register on the way.
- R6: The state advances at a clock edge only when in_valid_i, out_ready_i and ks_valid_o are all high and init_i is low. In every other cycle the next keystream is unchanged.
- R7: init_i loads the key into the state synchronously, with word i taken from key_i[i·N +: N]. ks_valid_o is high from the next cycle and stays high until reset. Init takes priority over a transfer, and in_ready_o and out_valid_o are low while init_i is high.
- R8: After reset, ks_valid_o, in_ready_o and out_valid_o are low until the first init.
- R9: A second core with the same key, fed from the first core's output, returns the original plaintext.
- R10: With N_BITS=64 and M_WORDS=8 (512-bit key), the core follows the same step rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Load key and mark keystream valid |
| key_i | input | M_WORDS*N_BITS | Key, word i at bits [i·N +: N] |
| in_valid_i | input | 1 | Input word present |
| in_data_i | input | M_WORDS*N_BITS | Plaintext or ciphertext |
| in_ready_o | output | 1 | Core accepts the input word |
| out_valid_o | output | 1 | Output word present |
| out_data_o | output | M_WORDS*N_BITS | Input XOR keystream |
| out_ready_i | input | 1 | Consumer accepts the output word |
| ks_valid_o | output | 1 | State holds a loaded key |

## Verification
out_data_o, out_valid_o and in_ready_o are combinational. The bench therefore samples them 1 ns after the falling edge at which it drives new inputs, in the same cycle. A state step or a key load shows up only after the next rising edge. The behavioural model in the bench updates its state at that edge, and its next comparison falls in the following cycle, one register later. The bijection sweep on an 8-bit map has no clock and settles 1 ns after each operand change.

// File: rtl/cks_pkg.sv
package cks_pkg;
  // constant parameter of the base-word map: this nibble repeated
  localparam logic [3:0] BASE_NIBBLE = 4'hB;
  // rotation is word width divided by this
  localparam int unsigned ROT_DIV = 4;
endpackage

// File: rtl/cks_map.sv
module cks_map #(
  parameter int unsigned N_BITS = 32
) (
  input  logic [N_BITS-1:0] p_i,
  input  logic [N_BITS-1:0] x_i,
  output logic [N_BITS-1:0] f_o
);
  logic [N_BITS-1:0] g_w, sq_w, lin_w;

  assign g_w   = p_i | N_BITS'(3);
  assign sq_w  = x_i * x_i;
  assign lin_w = g_w * x_i;
  assign f_o   = (sq_w << 1) + lin_w;

  always_comb begin
    if (!$isunknown({p_i, x_i})) begin
      // R2
      odd_keep_chk: assert (f_o[0] == x_i[0]);
    end
  end
endmodule

// File: rtl/cks_step.sv
module cks_step
  import cks_pkg::*;
#(
  parameter int unsigned N_BITS  = 32,
  parameter int unsigned M_WORDS = 4
) (
  input  logic [M_WORDS-1:0][N_BITS-1:0] state_i,
  output logic [M_WORDS-1:0][N_BITS-1:0] ks_o
);
  localparam int unsigned ROT = N_BITS / ROT_DIV;
  localparam logic [N_BITS-1:0] BASE_C = {(N_BITS/4){BASE_NIBBLE}};

  logic [N_BITS-1:0] upd [M_WORDS];

  cks_map #(.N_BITS(N_BITS)) u_base (
    .p_i(BASE_C), .x_i(state_i[0]), .f_o(upd[0])
  );

  // skew chain: each map keyed by the word updated just before it
  for (genvar gi = 1; gi < M_WORDS; gi++) begin : g_chain
    cks_map #(.N_BITS(N_BITS)) u_map (
      .p_i(upd[gi-1]), .x_i(state_i[gi]), .f_o(upd[gi])
    );
  end

  for (genvar gi = 0; gi < M_WORDS; gi++) begin : g_rot
    assign ks_o[gi] = {upd[gi][N_BITS-ROT-1:0], upd[gi][N_BITS-1:N_BITS-ROT]};
  end
endmodule

// File: rtl/cks_state.sv
module cks_state #(
  parameter int unsigned N_BITS  = 32,
  parameter int unsigned M_WORDS = 4,
  localparam int unsigned KEY_W  = N_BITS * M_WORDS
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          init_i,
  input  logic [KEY_W-1:0]              key_i,
  input  logic                          adv_i,
  input  logic [M_WORDS-1:0][N_BITS-1:0] next_i,
  output logic [M_WORDS-1:0][N_BITS-1:0] state_o,
  output logic                          ks_valid_o
);
  logic [M_WORDS-1:0][N_BITS-1:0] state_q;
  logic                           ks_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= '0;
      ks_valid_q <= 1'b0;
    end else if (init_i) begin
      state_q    <= key_i;
      ks_valid_q <= 1'b1;
    end else if (adv_i) begin
      state_q    <= next_i;
    end
  end

  assign state_o    = state_q;
  assign ks_valid_o = ks_valid_q;

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !adv_i) |=> $stable(state_q));
  // R7
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (state_q == $past(key_i)));
  // R7
  ksv_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ks_valid_q |=> ks_valid_q);
endmodule

// File: rtl/chaos_keystream_core.sv
module chaos_keystream_core #(
  parameter int unsigned N_BITS  = 32,
  parameter int unsigned M_WORDS = 4,
  localparam int unsigned KEY_W  = N_BITS * M_WORDS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             in_valid_i,
  input  logic [KEY_W-1:0] in_data_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [KEY_W-1:0] out_data_o,
  input  logic             out_ready_i,
  output logic             ks_valid_o
);
  logic [M_WORDS-1:0][N_BITS-1:0] state_w, ks_w;
  logic ksv_w, fire_w;

  cks_step #(.N_BITS(N_BITS), .M_WORDS(M_WORDS)) u_step (
    .state_i(state_w), .ks_o(ks_w)
  );

  cks_state #(.N_BITS(N_BITS), .M_WORDS(M_WORDS)) u_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .key_i(key_i),
    .adv_i(fire_w), .next_i(ks_w), .state_o(state_w), .ks_valid_o(ksv_w)
  );

  assign in_ready_o  = ksv_w & out_ready_i & ~init_i;
  assign out_valid_o = ksv_w & in_valid_i & ~init_i;
  assign fire_w      = in_ready_o & in_valid_i;
  assign out_data_o  = in_data_i ^ ks_w;
  assign ks_valid_o  = ksv_w;

  // R8
  gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ks_valid_o |-> (!in_ready_o && !out_valid_o));
  // R7
  init_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> ks_valid_o);
endmodule

// File: tb/chaos_keystream_core_test.sv
module chaos_keystream_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // 32x4 encryptor and decryptor
  logic         init_e = 0, vld = 0, rdy = 0;
  logic [127:0] key_e = '0, pt = '0;
  logic         e_ir, e_ov, e_ksv, d_ir, d_ov, d_ksv;
  logic [127:0] ct, rt;

  chaos_keystream_core uut (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init_e), .key_i(key_e),
    .in_valid_i(vld), .in_data_i(pt), .in_ready_o(e_ir),
    .out_valid_o(e_ov), .out_data_o(ct), .out_ready_i(rdy & d_ir),
    .ks_valid_o(e_ksv)
  );
  chaos_keystream_core u_dec (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init_e), .key_i(key_e),
    .in_valid_i(e_ov), .in_data_i(ct), .in_ready_o(d_ir),
    .out_valid_o(d_ov), .out_data_o(rt), .out_ready_i(rdy),
    .ks_valid_o(d_ksv)
  );

  // 64x8 core
  logic         init_b = 0;
  logic [511:0] key_b = '0, bo;
  logic         b_ir, b_ov, b_ksv;
  chaos_keystream_core #(.N_BITS(64), .M_WORDS(8)) u_big (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init_b), .key_i(key_b),
    .in_valid_i(1'b1), .in_data_i('0), .in_ready_o(b_ir),
    .out_valid_o(b_ov), .out_data_o(bo), .out_ready_i(1'b1),
    .ks_valid_o(b_ksv)
  );

  // 8-bit map for exhaustive sweep
  logic [7:0] p8 = 0, x8 = 0, f8;
  cks_map #(.N_BITS(8)) u_map8 (.p_i(p8), .x_i(x8), .f_o(f8));

  // ---------------- behavioural model ----------------
  function automatic bit [63:0] msk(int n);
    return (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction
  function automatic bit [63:0] fm(bit [63:0] p, bit [63:0] x, int n);
    return (((x * x) << 1) + ((p | 64'd3) * x)) & msk(n);
  endfunction
  function automatic bit [63:0] cst(int n);
    bit [63:0] c = 0;
    for (int k = 0; k < n / 4; k++) c = (c << 4) | 64'hB;
    return c;
  endfunction
  function automatic bit [63:0] rl(bit [63:0] w, int n);
    int r = n / 4;
    return ((w << r) | (w >> (n - r))) & msk(n);
  endfunction
  task automatic adv(ref bit [63:0] s[16], input int n, input int m);
    bit [63:0] t[16];
    t[0] = fm(cst(n), s[0], n);
    for (int i = 1; i < m; i++) t[i] = fm(t[i-1], s[i], n);
    for (int i = 0; i < m; i++) s[i] = rl(t[i], n);
  endtask
  function automatic bit [511:0] pk(bit [63:0] s[16], int n, int m);
    bit [511:0] v = '0;
    for (int i = 0; i < m; i++) begin
      bit [511:0] t = 512'(s[i]);
      v |= t << (i * n);
    end
    return v;
  endfunction
  task automatic ld(ref bit [63:0] s[16], input bit [511:0] k, input int n, input int m);
    for (int i = 0; i < m; i++) s[i] = 64'(k >> (i * n)) & msk(n);
  endtask

  bit [63:0] es[16];
  bit [63:0] bs[16];
  bit        mksv = 0, bksv = 0;

  task automatic chk(bit ok, string req, bit [511:0] act, bit [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one cycle of the 32x4 pair; inputs already driven at negedge
  task automatic cyc();
    bit [63:0] tmp[16];
    bit ev, er, fire;
    #1;
    ev = mksv && vld && !init_e;
    er = mksv && rdy && !init_e;
    fire = ev && er;
    chk(e_ov == ev, mksv ? (init_e ? "R7 out_valid" : "R6 out_valid") : "R8 out_valid", 512'(e_ov), 512'(ev));
    chk(e_ir == er, mksv ? (init_e ? "R7 in_ready" : "R6 in_ready") : "R8 in_ready", 512'(e_ir), 512'(er));
    tmp = es;
    adv(tmp, 32, 4);
    if (ev) begin
      chk(ct == (pt ^ pk(tmp, 32, 4)[127:0]), "R5 R3 R4 out_data", 512'(ct), 512'(pt ^ pk(tmp, 32, 4)[127:0]));
      chk(d_ov && rt == pt, "R9 round trip", 512'(rt), 512'(pt));
    end
    @(posedge clk);
    if (init_e) begin
      ld(es, 512'(key_e), 32, 4);
      mksv = 1;
    end else if (fire) es = tmp;
    @(negedge clk);
  endtask

  task automatic cyc_big();
    bit [63:0] tmp[16];
    #1;
    chk(b_ov == (bksv && !init_b), "R10 out_valid", 512'(b_ov), 512'(bksv && !init_b));
    tmp = bs;
    adv(tmp, 64, 8);
    if (bksv && !init_b) chk(bo == pk(tmp, 64, 8), "R10 keystream", bo, pk(tmp, 64, 8));
    @(posedge clk);
    if (init_b) begin
      ld(bs, key_b, 64, 8);
      bksv = 1;
    end else if (bksv) bs = tmp;
    @(negedge clk);
  endtask

  int unsigned lcg = 32'h1234_5678;
  function automatic logic [127:0] nxt_pt();
    logic [127:0] v;
    for (int k = 0; k < 4; k++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      v[k*32 +: 32] = lcg;
    end
    return v;
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) begin es[i] = 0; bs[i] = 0; end
    repeat (2) @(negedge clk);
    #1;
    chk(!e_ksv && !e_ir && !e_ov, "R8 reset state", 512'({e_ksv, e_ir, e_ov}), 512'(0));
    rst_n = 1;
    @(negedge clk);
    // valid and ready before any init: nothing moves
    vld = 1; rdy = 1; pt = nxt_pt();
    cyc();
    cyc();
    // R1 spot values on the 8-bit map
    p8 = 0; x8 = 1; #1;
    chk(f8 == 8'd5, "R1 f(0,1)", 512'(f8), 512'd5);
    p8 = 4; #1;
    chk(f8 == 8'd9, "R1 f(4,1)", 512'(f8), 512'd9);
    p8 = 7; #1;
    chk(f8 == 8'd9, "R1 g forces low bits", 512'(f8), 512'd9);
    // R2 exhaustive bijection at N=8
    for (int p = 0; p < 256; p++) begin
      logic [255:0] seen = '0;
      int bad = 0;
      for (int x = 0; x < 256; x++) begin
        p8 = 8'(p); x8 = 8'(x); #1;
        seen[f8] = 1'b1;
        if (64'(f8) != fm(64'(p), 64'(x), 8)) bad++;
      end
      chk(&seen, "R2 bijection", 512'(seen), {256'd0, {256{1'b1}}});
      chk(bad == 0, "R1 map formula", 512'(bad), 512'd0);
    end
    @(negedge clk);
    // key 1: explicit first keystream (R4)
    init_e = 1; key_e = 128'h1; vld = 1; rdy = 1;
    cyc();
    init_e = 0; pt = '0;
    #1;
    chk(ct == 128'h0000_0000_0000_0000_0000_0000_BBBB_BDBB, "R4 key-one keystream", 512'(ct), 512'h0000_0000_0000_0000_0000_0000_BBBB_BDBB);
    cyc();
    // all-zero key stays zero (R3)
    init_e = 1; key_e = '0;
    cyc();
    init_e = 0;
    for (int k = 0; k < 3; k++) begin
      pt = nxt_pt();
      #1;
      chk(ct == pt, "R3 zero fixed point", 512'(ct), 512'(pt));
      cyc();
    end
    // main key with mixed handshake patterns (R5 R6 R9)
    init_e = 1; key_e = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    cyc();
    init_e = 0;
    for (int k = 0; k < 40; k++) begin
      vld = (k % 3) != 0;
      rdy = (k % 4) != 1;
      pt  = nxt_pt();
      cyc();
    end
    // stall: hold off, then resume (R6)
    vld = 0; rdy = 1;
    repeat (3) cyc();
    vld = 1; rdy = 0;
    repeat (3) cyc();
    vld = 1; rdy = 1; pt = nxt_pt();
    cyc();
    // init collides with a transfer: init wins (R7)
    init_e = 1; key_e = 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555; pt = nxt_pt();
    cyc();
    init_e = 0;
    #1;
    chk(e_ksv == 1'b1, "R7 ks_valid after init", 512'(e_ksv), 512'd1);
    for (int k = 0; k < 8; k++) begin pt = nxt_pt(); cyc(); end
    // 512-bit configuration (R10)
    for (int i = 0; i < 64; i++) key_b[i*8 +: 8] = 8'(i * 37 + 5);
    cyc_big();
    init_b = 1;
    cyc_big();
    init_b = 0;
    repeat (6) cyc_big();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule